// File: doc/BRIEF.md
# Indexed Byte-Store Access Port with Lockable Windows

This block gives a host byte-wide access to a local byte memory through a four-offset port. The host first loads a 16-bit address pointer one byte at a time: one offset replaces the low half, another the high half. A data write then stores a byte at the pointed address and returns the pointer to zero, so the next transfer starts from a known place. A data read returns the pointed byte one cycle later and leaves the pointer where it was.

Two fixed 16-byte windows can be locked on their own. A separate toggle command flips one lock bit. While a window is locked, stores into it are dropped and loads from it return all ones. Addresses at or above the memory depth behave the same way. Reset clears the pointer and the lock bits. It leaves the memory contents alone.

Top module: `nvp_port`

## Requirements
- R1: A write at offset 0 replaces bits 7:0 of the pointer with the written byte and leaves bits 15:8 unchanged.
- R2: A write at offset 1 replaces bits 15:8 of the pointer with the written byte and leaves bits 7:0 unchanged.
- R3: A write at offset 3 stores the byte at the pointer address (when that address is accessible) and sets the pointer to 0x0000 in the same cycle, whether or not the store took place.
- R4: A read at offset 3 raises `rd_valid` for exactly one cycle on the following clock edge, with `rd_data` holding the byte at the pointer address; reads leave the pointer unchanged, and `rd_valid` stays low in cycles after non-read accesses.
- R5: While lock bit 0 is set, addresses 0x0020 to 0x002F are protected: stores there are ignored and reads there return 0xFF.
- R6: While lock bit 1 is set, addresses 0x0030 to 0x003F are protected in the same way; each lock bit affects only its own window.
- R7: A toggle command with index n inverts lock bit n; the new value applies to accesses from the next cycle on.
- R8: Addresses at or above `MEM_BYTES` (default 2048) read as 0xFF, and stores to them are ignored and never alias onto lower addresses.
- R9: Reads at offsets 0, 1 and 2 return 0xFF, and a write at offset 2 changes neither the pointer nor the memory.
- R10: Reset clears the pointer and both lock bits; memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Single-byte port access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 2 | Port offset: 0 low address, 1 high address, 3 data |
| acc_wdata | input | 8 | Write byte |
| lock_tgl | input | 1 | Toggle one lock bit this cycle |
| lock_idx | input | $clog2(NUM_WIN) | Index of the lock bit to toggle |
| rd_valid | output | 1 | Read result valid (one cycle after a read access) |
| rd_data | output | 8 | Read result byte |

## Verification
The pointer path is tried with full loads, low-only and high-only reloads, and reads repeated without a reload. These separate correct half-replacement from a whole-word load, and a stable pointer from one that increments or clears on reads. Stores are checked against a follow-up read of location zero, which reveals whether the pointer cleared after a write. Lock patterns toggle each bit alone and then both, and probe the first and last byte of each window and their neighbours. Stores just above the memory depth are read back at address zero, which exposes address truncation. A reset taken with locks set and the pointer non-zero shows that the state clears and the data is retained.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        OFF_ADDR_LO = 2'd0,
        OFF_ADDR_HI = 2'd1,
        OFF_SPARE   = 2'd2,
        OFF_DATA    = 2'd3
    } port_off_e;

    localparam logic [DATA_W-1:0] FILL_BYTE = '1;
endpackage

// File: rtl/nvp_ptr.sv
module nvp_ptr
    import nvp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic              clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HALF = ADDR_W / 2;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (ld_lo) begin
            st_d.ptr[HALF-1:0] = wdata[HALF-1:0];
        end else if (ld_hi) begin
            st_d.ptr[ADDR_W-1:HALF] = wdata[HALF-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/nvp_lock.sv
module nvp_lock
    import nvp_pkg::*;
#(
    parameter int NUM_WIN  = 2,
    parameter int WIN_BASE = 32,
    parameter int WIN_SIZE = 16,
    localparam int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tgl,
    input  logic [IDX_W-1:0]   tgl_idx,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] lock,
    output logic               blocked
);
    typedef struct packed {
        logic [NUM_WIN-1:0] bits;
    } lock_state_t;

    lock_state_t st_d, st_q;
    logic [NUM_WIN-1:0] hit;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(WIN_BASE + i * WIN_SIZE);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(WIN_BASE + (i + 1) * WIN_SIZE - 1);
        assign hit[i] = st_q.bits[i] && (addr >= LO) && (addr <= HI);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (tgl && (tgl_idx == IDX_W'(i))) st_d.bits[i] = ~st_q.bits[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock    = st_q.bits;
    assign blocked = |hit;
endmodule

// File: rtl/nvp_store.sv
module nvp_store
    import nvp_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              in_range
);
    localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W + 1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;

    assign in_range = ({1'b0, addr} < DEPTH_L);
    assign idx      = addr[IDX_W-1:0];
    assign rdata    = mem[idx];

    always_ff @(posedge clk) begin
        if (we && in_range) mem[idx] <= wdata;
    end
endmodule

// File: rtl/nvp_port.sv
module nvp_port
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 2048,
    parameter int NUM_WIN   = 2,
    parameter int WIN_BASE  = 32,
    parameter int WIN_SIZE  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [1:0]                 acc_off,
    input  logic [7:0]                 acc_wdata,
    input  logic                       lock_tgl,
    input  logic [$clog2(NUM_WIN)-1:0] lock_idx,
    output logic                       rd_valid,
    output logic [7:0]                 rd_data
);
    typedef struct packed {
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    logic [ADDR_W-1:0]  ptr_q;
    logic [NUM_WIN-1:0] lock_q;
    logic               win_blocked;
    logic               in_range;
    logic [DATA_W-1:0]  mem_rdata;
    logic               acc_rd, acc_wr, is_data;
    logic               ld_lo, ld_hi, data_wr, allowed, mem_we;

    always_comb begin
        acc_rd  = acc_valid && !acc_write;
        acc_wr  = acc_valid && acc_write;
        is_data = (acc_off == OFF_DATA);
        ld_lo   = acc_wr && (acc_off == OFF_ADDR_LO);
        ld_hi   = acc_wr && (acc_off == OFF_ADDR_HI);
        data_wr = acc_wr && is_data;
        allowed = in_range && !win_blocked;
        mem_we  = data_wr && allowed;
    end

    nvp_ptr u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .clr   (data_wr),
        .wdata (acc_wdata),
        .ptr   (ptr_q)
    );

    nvp_lock #(
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .tgl     (lock_tgl),
        .tgl_idx (lock_idx),
        .addr    (ptr_q),
        .lock    (lock_q),
        .blocked (win_blocked)
    );

    nvp_store #(
        .DEPTH (MEM_BYTES)
    ) u_store (
        .clk      (clk),
        .we       (mem_we),
        .addr     (ptr_q),
        .wdata    (acc_wdata),
        .rdata    (mem_rdata),
        .in_range (in_range)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = acc_rd;
        if (acc_rd) begin
            st_d.rd_data = (is_data && allowed) ? mem_rdata : FILL_BYTE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;
endmodule

// File: rtl/nvp_port_chk.sv
module nvp_port_chk #(
    parameter int WIN_BASE = 32,
    parameter int WIN_SIZE = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  acc_off,
    input logic [7:0]  acc_wdata,
    input logic        lock_tgl,
    input logic [0:0]  lock_idx,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic [15:0] ptr_q,
    input logic [1:0]  lock_q
);
    localparam logic [15:0] W0_LO = 16'(WIN_BASE);
    localparam logic [15:0] W0_HI = 16'(WIN_BASE + WIN_SIZE - 1);
    localparam logic [15:0] W1_LO = 16'(WIN_BASE + WIN_SIZE);
    localparam logic [15:0] W1_HI = 16'(WIN_BASE + 2 * WIN_SIZE - 1);

    // R1
    low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_off == 2'd0)
        |=> (ptr_q[7:0] == $past(acc_wdata)) && (ptr_q[15:8] == $past(ptr_q[15:8])));

    // R2
    high_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_off == 2'd1)
        |=> (ptr_q[15:8] == $past(acc_wdata)) && (ptr_q[7:0] == $past(ptr_q[7:0])));

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_off == 2'd3) |=> (ptr_q == 16'h0000));

    // R4
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> rd_valid);

    // R4
    no_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid);

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && acc_off != 2'd2) |=> (ptr_q == $past(ptr_q)));

    // R5
    win0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_off == 2'd3 && lock_q[0]
         && ptr_q >= W0_LO && ptr_q <= W0_HI) |=> (rd_data == 8'hFF));

    // R6
    win1_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_off == 2'd3 && lock_q[1]
         && ptr_q >= W1_LO && ptr_q <= W1_HI) |=> (rd_data == 8'hFF));

    // R7
    lock_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_tgl |=> (lock_q == ($past(lock_q) ^ (2'b01 << $past(lock_idx)))));

    // R7
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_tgl |=> (lock_q == $past(lock_q)));

    // R9
    spare_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_off != 2'd3) |=> (rd_data == 8'hFF));
endmodule

bind nvp_port nvp_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_off   (acc_off),
    .acc_wdata (acc_wdata),
    .lock_tgl  (lock_tgl),
    .lock_idx  (lock_idx),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ptr_q     (ptr_q),
    .lock_q    (lock_q)
);

// File: tb/nvp_port_tb_top.sv
module nvp_port_tb_top;
    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_write = 1'b0;
    logic [1:0] acc_off = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic       lock_tgl = 1'b0;
    logic [0:0] lock_idx = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;

    int mem_m [int];
    int ptr_m = 0;
    int lock_m = 0;

    always #2 clk = ~clk;

    nvp_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata),
        .lock_tgl  (lock_tgl),
        .lock_idx  (lock_idx),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    function automatic bit reachable(int a);
        if (a >= MEM) return 1'b0;
        if (lock_m[0] && a >= 32'h20 && a <= 32'h2F) return 1'b0;
        if (lock_m[1] && a >= 32'h30 && a <= 32'h3F) return 1'b0;
        return 1'b1;
    endfunction

    // One clock of stimulus; called at a falling edge, returns at the next one
    // and compares the outputs against the model on that clock.
    task automatic op(input bit v, input bit wr, input int off, input int d,
                      input bit tg, input int ti, input string tag);
        bit exp_v;
        int exp_d;
        acc_valid = v; acc_write = wr; acc_off = 2'(off); acc_wdata = 8'(d);
        lock_tgl = tg; lock_idx = 1'(ti);
        exp_v = v && !wr;
        exp_d = -1;
        if (exp_v) begin
            if (off != 3 || !reachable(ptr_m)) exp_d = 8'hFF;
            else if (mem_m.exists(ptr_m)) exp_d = mem_m[ptr_m];
        end
        if (v && wr) begin
            if (off == 0) ptr_m = (ptr_m & 32'hFF00) | (d & 8'hFF);
            else if (off == 1) ptr_m = (ptr_m & 32'h00FF) | ((d & 8'hFF) << 8);
            else if (off == 3) begin
                if (reachable(ptr_m)) mem_m[ptr_m] = d & 8'hFF;
                ptr_m = 0;
            end
        end
        if (tg) lock_m = lock_m ^ (1 << ti);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; lock_tgl = 1'b0;
        tests++;
        if (rd_valid !== exp_v) begin
            fails++;
            $display("FAIL %s rd_valid actual %0b expected %0b", tag, rd_valid, exp_v);
        end else if (exp_v && exp_d >= 0 && rd_data !== 8'(exp_d)) begin
            fails++;
            $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, exp_d);
        end
    endtask

    task automatic wr(input int off, input int d, input string tag);
        op(1'b1, 1'b1, off, d, 1'b0, 0, tag);
    endtask

    task automatic rd(input int off, input string tag);
        op(1'b1, 1'b0, off, 0, 1'b0, 0, tag);
    endtask

    task automatic set_ptr(input int a, input string tag);
        wr(0, a & 8'hFF, tag);
        wr(1, (a >> 8) & 8'hFF, tag);
    endtask

    task automatic store(input int a, input int d, input string tag);
        set_ptr(a, tag);
        wr(3, d, tag);
    endtask

    task automatic load(input int a, input string tag);
        set_ptr(a, tag);
        rd(3, tag);
    endtask

    task automatic toggle(input int i, input string tag);
        op(1'b0, 1'b0, 0, 0, 1'b1, i, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ptr_m = 0;
        lock_m = 0;
        rst_n = 1'b1;
        op(1'b0, 1'b0, 0, 0, 1'b0, 0, "R10 idle after reset");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R3 / R10: pointer is zero after reset, data write stores there
        wr(3, 8'h5A, "R3");
        rd(3, "R10 pointer zero");

        // R4: read at pointer, repeated reads keep pointer
        store(16'h0123, 8'hA1, "R3");
        load(16'h0123, "R4");
        rd(3, "R4 repeat");
        rd(3, "R4 repeat");

        // R3: pointer cleared after data write
        store(16'h0123, 8'h77, "R3");
        rd(3, "R3 cleared pointer");

        // R1 / R2: half replacement
        store(16'h0457, 8'h33, "R1");
        store(16'h0456, 8'h44, "R1");
        store(16'h0557, 8'h66, "R2");
        set_ptr(16'h0456, "R1");
        wr(0, 8'h57, "R1");
        rd(3, "R1 low only");
        wr(1, 8'h05, "R2");
        rd(3, "R2 high only");

        // R9: spare offsets
        rd(0, "R9");
        rd(1, "R9");
        rd(2, "R9");
        set_ptr(16'h0456, "R9");
        wr(2, 8'h99, "R9");
        rd(3, "R9 spare write");

        // R5 / R6 / R7: windows
        store(16'h20, 8'h10, "R5");
        store(16'h25, 8'h11, "R5");
        store(16'h2F, 8'h12, "R5");
        store(16'h30, 8'h20, "R6");
        store(16'h35, 8'h22, "R6");
        store(16'h3F, 8'h23, "R6");
        store(16'h1F, 8'h1F, "R5");
        store(16'h40, 8'h40, "R6");
        toggle(0, "R7");
        load(16'h20, "R5 locked low edge");
        load(16'h25, "R5 locked");
        load(16'h2F, "R5 locked high edge");
        load(16'h1F, "R5 neighbour");
        load(16'h30, "R6 unaffected by bit0");
        store(16'h25, 8'hEE, "R5 ignored write");
        toggle(0, "R7");
        load(16'h25, "R7 unlock");
        toggle(1, "R7");
        load(16'h30, "R6 locked low edge");
        load(16'h3F, "R6 locked high edge");
        store(16'h35, 8'hCC, "R6 ignored write");
        load(16'h40, "R6 neighbour");
        load(16'h2F, "R6 bit1 only");
        toggle(0, "R7 both");
        load(16'h2F, "R5 both locked");
        toggle(1, "R7");
        load(16'h35, "R6 unlock");

        // R8: beyond memory depth
        store(16'h07FF, 8'h7E, "R8");
        load(16'h07FF, "R8 last byte");
        store(16'h0800, 8'hAB, "R8");
        load(16'h0800, "R8 beyond");
        load(16'hFFFF, "R8 top");
        load(16'h0000, "R8 no alias");

        // R10: reset with locks set and pointer non-zero
        set_ptr(16'h0457, "R10");
        do_reset();
        rd(3, "R10 memory kept");
        load(16'h25, "R10 lock cleared");

        finish_run();
    end
endmodule